// File: doc/BRIEF.md
# Gaussian FSK Transmit Shaper

This block turns a serial transmit bit stream into a signed frequency-deviation word that steers a directly modulated oscillator. It runs on the filter clock, which is six times the bit rate: 6.912 MHz against 1.152 Mbit/s. Each clock it samples the data line, so every bit shows up as six identical samples. Each sample is mapped to a symbol of +1 for a one or -1 for a zero. The six most recent samples pass through a symmetric six-tap FIR whose integer weights approximate a Gaussian pulse with BT = 0.5. The weights sum to 64, so a steady symbol gives a filtered value of ±64.

The filtered value is then scaled by a 3-bit deviation code, from 60 % to 130 % in 10 % steps, relative to a nominal peak of 400 kHz. One output LSB stands for 1 kHz. The result is clipped to a 10-bit signed range.

When shaping is switched off, or the transmitter is not in TX mode, the FIR is bypassed. In that case the newest unfiltered symbol is scaled instead, which gives a square deviation. The enable, mode and code inputs are registered on the same edge as the data sample. A change of setting therefore lines up with the bit it arrives with.

Top module: `gfsk_shaper`

## Requirements
- R1: While reset is held, `dev_word` is 0 and `dev_valid` is 0.
- R2: `dev_valid` goes high on the seventh rising edge after reset is released, which is the first output built from six real samples. It then stays high until the next reset.
- R3: With shaping on, TX mode on and `dev_code` = 4 (100 %), a steady run of ones gives `dev_word` = +400 and a steady run of zeros gives -400.
- R4: The filtered value is the sum over the last six samples of weight × symbol, where a one is +1 and a zero is -1. The weights are 3, 10, 19, 19, 10 and 3 from newest to oldest. A sample driven before rising edge k first affects `dev_word` after edge k+1.
- R5: `dev_word` = floor(filtered × (6 + `dev_code`) × 5 / 8), so a half-LSB result is rounded toward minus infinity.
- R6: `dev_code` values 0 to 7 select 60 % to 130 % in 10 % steps. A steady run of ones gives 240, 280, 320, 360, 400, 440 and 480 for codes 0 to 6. Enable, mode and code are registered together with the data sample they accompany.
- R7: Results beyond the 10-bit signed range saturate. A steady run of ones at code 7 gives +511 instead of 520, and a steady run of zeros at code 7 gives -512.
- R8: With `shape_en` = 0, the filtered value is replaced by ±64 from the newest sample alone, so `dev_word` jumps straight between +dev and -dev with no intermediate values.
- R9: With `shape_en` = 1 but `tx_mode` = 0, the output is the same bypass as in R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock, six cycles per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_bit | input | 1 | Serial transmit data, sampled every clock |
| shape_en | input | 1 | 1 = Gaussian shaping on |
| tx_mode | input | 1 | 1 = transmitter active; shaping only applies when set |
| dev_code | input | 3 | Deviation code, 0 to 7 for 60 % to 130 % |
| dev_word | output | 10 | Signed deviation word, 1 kHz per LSB |
| dev_valid | output | 1 | Output built from a full six-sample window |

## Verification
A sample and its control settings are captured on the first rising edge after they are driven, and the matching deviation word appears one edge later. Every result is therefore due two rising edges after its stimulus. The driver queues one expected item for each sample it drives. The monitor holds each item for one edge and compares it one time unit after the second edge, so every output is read after it has settled and before the next update. The expected words come from a model of the six-sample history and the scaling formula, which covers the transition values, the rounding, the saturation and the bypass cases.

// File: rtl/gfsk_shaper.sv
module gfsk_shaper #(
  parameter int WORD_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tx_bit,
  input  logic                     shape_en,
  input  logic                     tx_mode,
  input  logic [2:0]               dev_code,
  output logic signed [WORD_W-1:0] dev_word,
  output logic                     dev_valid
);
  localparam int NTAP = 6;
  localparam logic signed [7:0] UNITY = 8'sd64;
  localparam logic signed [7:0] COEF [NTAP] = '{8'sd3, 8'sd10, 8'sd19, 8'sd19, 8'sd10, 8'sd3};
  localparam logic signed [15:0] SAT_HI = 16'(2 ** (WORD_W - 1) - 1);
  localparam logic signed [15:0] SAT_LO = -16'(2 ** (WORD_W - 1));

  logic [NTAP-1:0] win;
  logic [2:0]      fill;
  logic            en_q, mode_q;
  logic [2:0]      code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win    <= '0;
      fill   <= '0;
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      code_q <= '0;
    end else begin
      win    <= {win[NTAP-2:0], tx_bit};
      fill   <= (fill == 3'(NTAP)) ? fill : fill + 3'd1;
      en_q   <= shape_en;
      mode_q <= tx_mode;
      code_q <= dev_code;
    end
  end

  logic signed [7:0] fir_sum;
  always_comb begin
    fir_sum = '0;
    for (int k = 0; k < NTAP; k++)
      fir_sum = fir_sum + (win[k] ? COEF[k] : -COEF[k]);
  end

  logic signed [7:0]  shaped;
  logic [6:0]         scale;
  logic signed [15:0] prod, quot, clipped;

  assign shaped  = (en_q && mode_q) ? fir_sum : (win[0] ? UNITY : -UNITY);
  assign scale   = (7'd6 + {4'd0, code_q}) * 7'd5;
  assign prod    = {{8{shaped[7]}}, shaped} * $signed({9'd0, scale});
  assign quot    = prod >>> 3;
  assign clipped = (quot > SAT_HI) ? SAT_HI : (quot < SAT_LO) ? SAT_LO : quot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_word  <= '0;
      dev_valid <= 1'b0;
    end else begin
      dev_word  <= clipped[WORD_W-1:0];
      dev_valid <= (fill == 3'(NTAP));
    end
  end
endmodule

module gfsk_shaper_chk #(
  parameter int WORD_W = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [5:0]               win,
  input logic [2:0]               fill,
  input logic                     en_q,
  input logic                     mode_q,
  input logic [2:0]               code_q,
  input logic signed [WORD_W-1:0] dev_word,
  input logic                     dev_valid
);
  assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid |=> dev_valid);

  assert_valid_not_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill != 3'd6) |=> !dev_valid);

  assert_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (win == 6'h3F && en_q && mode_q && code_q == 3'd4) |=> (dev_word == WORD_W'(400)));

  assert_bypass_square_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(en_q && mode_q) && code_q == 3'd4) |=> (dev_word == WORD_W'(400) || dev_word == -WORD_W'(400)));

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win == 6'h00 && en_q && mode_q && code_q == 3'd7) |=> (dev_word == -WORD_W'(2 ** (WORD_W - 1))));
endmodule

bind gfsk_shaper gfsk_shaper_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .win(win), .fill(fill), .en_q(en_q), .mode_q(mode_q),
  .code_q(code_q), .dev_word(dev_word), .dev_valid(dev_valid)
);

// File: tb/tb_gfsk_shaper.sv
`timescale 1ns/1ps
module tb_gfsk_shaper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_bit = 1'b0, shape_en = 1'b0, tx_mode = 1'b0;
  logic [2:0] dev_code = 3'd0;
  logic signed [9:0] dev_word;
  logic dev_valid;

  always #2.5 clk = ~clk;

  gfsk_shaper dut (
    .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .shape_en(shape_en), .tx_mode(tx_mode),
    .dev_code(dev_code), .dev_word(dev_word), .dev_valid(dev_valid)
  );

  typedef struct { int word; bit valid; string req; } item_t;
  item_t q[$];
  item_t stage;
  bit stage_full = 0;
  int checks = 0, fails = 0;
  bit done = 0;
  bit [5:0] hist = '0;
  int nsamp = 0;

  function automatic int model(bit [5:0] h, bit en, bit md, int code);
    int w[6] = '{3, 10, 19, 19, 10, 3};
    int f = 0, p, r;
    if (en && md) begin
      for (int k = 0; k < 6; k++) f += h[k] ? w[k] : -w[k];
    end else f = h[0] ? 64 : -64;
    p = f * (6 + code) * 5;
    r = (p >= 0) ? p / 8 : -((-p + 7) / 8);
    if (r > 511) r = 511;
    if (r < -512) r = -512;
    return r;
  endfunction

  task automatic drive(bit b, bit en, bit md, int code, string req);
    item_t it;
    @(negedge clk);
    rst_n = 1'b1;
    tx_bit = b; shape_en = en; tx_mode = md; dev_code = 3'(code);
    hist = {hist[4:0], b};
    nsamp++;
    it.word = model(hist, en, md, code);
    it.valid = (nsamp >= 6);
    it.req = req;
    q.push_back(it);
  endtask

  task automatic run(bit b, int n, bit en, bit md, int code, string req);
    for (int i = 0; i < n; i++) drive(b, en, md, code, req);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (stage_full) begin
        checks++;
        if (dev_valid !== stage.valid) begin
          fails++;
          $display("FAIL %s valid: actual %0b expected %0b", stage.req, dev_valid, stage.valid);
        end else if (stage.valid && int'(dev_word) != stage.word) begin
          fails++;
          $display("FAIL %s word: actual %0d expected %0d", stage.req, dev_word, stage.word);
        end
      end
      stage_full = 0;
      if (q.size() > 0) begin
        stage = q.pop_front();
        stage_full = 1;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (dev_word !== 10'sd0 || dev_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: actual word %0d valid %0b expected 0 0", dev_word, dev_valid);
    end
    run(1, 12, 1, 1, 4, "R2 R3 high");
    run(0, 8, 1, 1, 4, "R3 R4 R5 falling");
    for (int r = 0; r < 3; r++) begin
      drive(1, 1, 1, 4, "R4 R5 pattern");
      drive(0, 1, 1, 4, "R4 R5 pattern");
      drive(1, 1, 1, 4, "R4 R5 pattern");
      drive(1, 1, 1, 4, "R4 R5 pattern");
      drive(0, 1, 1, 4, "R4 R5 pattern");
      drive(0, 1, 1, 4, "R4 R5 pattern");
    end
    for (int c = 0; c < 8; c++) run(1, 7, 1, 1, c, (c == 7) ? "R7 high sat" : "R6 code sweep");
    run(0, 7, 1, 1, 7, "R7 low sat");
    for (int i = 0; i < 10; i++) drive(i[0], 1, 1, i % 8, "R6 code per sample");
    for (int i = 0; i < 12; i++) drive(i[1], 0, 1, 4, "R8 bypass disabled");
    for (int i = 0; i < 12; i++) drive(i[0], 1, 0, 5, "R9 bypass not tx");
    run(1, 3, 1, 1, 4, "R4 resume shaping");
    run(1, 6, 1, 1, 4, "R3 resume steady");
    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule